// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming front end of one eight-input priority interrupt controller. Software reaches it through a byte-wide register window with a one-bit address: address 0 is the command port and address 1 is the data port. After reset the controller is not ready. A command write with bit 4 set opens an initialization sequence. The next three data-port writes supply the vector base, a cascade word and a mode word. Once the sequence has completed, data-port writes program the interrupt mask. Command-port writes then carry either an end-of-interrupt/rotation word or a read-select/poll word.

The sequencer does not resolve priority itself. It hands the mask, the vector base, the auto-EOI, rotate and poll flags, one-cycle end-of-interrupt and set-priority commands, and an initialization pulse to a neighbouring resolver. It receives that resolver's request and in-service vectors back so that software can read them. Only cascaded operation with the fourth initialization word and 8086 vector mode is supported. Any other setting raises a configuration error and leaves the controller not ready.

Top module: `pic_cmd_seq`

## Requirements
- R1: A command-port write with bit 4 = 1 starts initialization. On the following cycle `ready_o` = 0, `mask_o` = 0, the read-select is returned to the request vector, and `init_o` is high for exactly one cycle (the resolver clears its priority pointer on this pulse).
- R2: If that start word has bit 1 (single mode) = 1 or bit 0 (fourth word expected) = 0:
  - `cfg_err_o` becomes 1 and the controller stays not ready.
  - Data-port writes are then ignored until the next start word.
  - A valid start word clears `cfg_err_o`.
- R3: The first data-port write after a valid start word loads `vec_base_o` with the written value ANDed with 0xF8. The second data-port write is accepted and changes no output.
- R4: The third data-port write is the mode word:
  - With bit 0 (8086 mode) = 1, it sets `ready_o`, loads `auto_eoi_o` from bit 1 and clears `cfg_err_o`.
  - With bit 0 = 0, it sets `cfg_err_o`, leaves the controller not ready, and the next data write is taken as the mode word again.
- R5: While ready, a data-port write loads `mask_o` with the full byte. While not ready, data writes outside the initialization steps and command writes with bit 4 = 0 change no output.
- R6: While ready, a command write with bit 4 = 0 and bit 3 = 1 loads `poll_o` from bit 2. If bit 1 = 1 it also loads the read-select from bit 0 (1 selects in-service, 0 selects request); if bit 1 = 0 the read-select is kept.
- R7: While ready, a command write with bits 4 and 3 = 0 is the EOI/rotation word:
  - `rotate_o` takes bit 7 and `cmd_lvl_o` takes bits 2:0.
  - If bit 5 = 1, `eoi_o` pulses for one cycle with `eoi_spec_o` = bit 6.
  - Otherwise, if bits 6 and 7 are both 1, `prio_set_o` pulses for one cycle.
- R8: A read strobe updates `rdata_o` on the next cycle, and `rdata_o` holds until the next read:
  - Address 1 returns the mask.
  - Address 0 returns `isr_i` when in-service is selected, else `irr_i`.
- R9: A read while `poll_o` = 1 returns 0 on `rdata_o` and pulses `rd_unsup_o` for one cycle.
- R10: After reset, all of the following are 0:
  - the flags `ready_o`, `auto_eoi_o`, `rotate_o`, `poll_o`, `cfg_err_o`
  - the pulses `init_o`, `eoi_o`, `prio_set_o`
  - `mask_o`, `vec_base_o` and `rdata_o`
  - the read-select, which starts on the request vector

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 1 | 0 = command port, 1 = data port |
| wdata_i | input | DW | Write data |
| irr_i | input | DW | Request vector from the resolver |
| isr_i | input | DW | In-service vector from the resolver |
| rdata_o | output | DW | Registered read data |
| ready_o | output | 1 | Initialization complete |
| mask_o | output | DW | Interrupt mask |
| vec_base_o | output | DW | Vector base, low bits zero |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt mode |
| rotate_o | output | 1 | Rotation flag from the last EOI/rotation word |
| poll_o | output | 1 | Poll flag |
| init_o | output | 1 | One-cycle pulse after a start word |
| eoi_o | output | 1 | One-cycle end-of-interrupt command |
| eoi_spec_o | output | 1 | EOI names a level (1) or the highest in service (0) |
| prio_set_o | output | 1 | One-cycle set-lowest-priority command |
| cmd_lvl_o | output | LVL_W | Level carried by the last EOI/rotation word |
| cfg_err_o | output | 1 | Unsupported initialization setting |
| rd_unsup_o | output | 1 | One-cycle pulse for a read made while polling |

## Verification
Every result of a write (flags, mask, vector base and the EOI, set-priority and init pulses) is due one cycle after the write strobe. A read result is due one cycle after the read strobe. The bench raises each strobe at a falling edge and drops it at the next falling edge, so exactly one rising edge sees it. It samples the outputs at that same falling edge, and it samples once more a cycle later where a pulse must have dropped again. The irr_i and isr_i values are held steady across each read, so the expected read data is fixed before the strobe.

// File: rtl/pic_cmd_seq_pkg.sv
package pic_cmd_seq_pkg;

   // Initialization progress. Values of the step register.
   typedef enum logic [2:0] {
      STEP_IDLE = 3'd0,
      STEP_HALT = 3'd1,
      STEP_BASE = 3'd2,
      STEP_CASC = 3'd3,
      STEP_MODE = 3'd4
   } step_e;

   // Command-port decode
   localparam int unsigned B_START = 4;
   localparam int unsigned B_SELW  = 3;

   // Start word
   localparam int unsigned B_SNGL  = 1;
   localparam int unsigned B_NEED4 = 0;

   // Mode word
   localparam int unsigned B_X86   = 0;
   localparam int unsigned B_AUTO  = 1;

   // EOI/rotation word
   localparam int unsigned B_ROT   = 7;
   localparam int unsigned B_LVLSP = 6;
   localparam int unsigned B_EOI   = 5;

   // Read-select word
   localparam int unsigned B_POLL  = 2;
   localparam int unsigned B_RDREG = 1;
   localparam int unsigned B_ISSEL = 0;

endpackage

// File: rtl/pic_cmd_seq_init.sv
module pic_cmd_seq_init
   import pic_cmd_seq_pkg::*;
#(
   parameter int DW    = 8,
   parameter int LVL_W = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_i,
   input  logic          addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic          ready_o,
   output logic [DW-1:0] mask_o,
   output logic [DW-1:0] vec_base_o,
   output logic          auto_eoi_o,
   output logic          cfg_err_o,
   output logic          init_o,
   output logic          start_o,
   output logic          op_wr_o
);

   step_e step_q;

   logic start_w;
   logic dwr_w;

   assign start_w = wr_i & ~addr_i & wdata_i[B_START];
   assign dwr_w   = wr_i & addr_i;
   assign start_o = start_w;
   assign op_wr_o = wr_i & ~addr_i & ~wdata_i[B_START] & ready_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         step_q     <= STEP_IDLE;
         ready_o    <= 1'b0;
         mask_o     <= '0;
         vec_base_o <= '0;
         auto_eoi_o <= 1'b0;
         cfg_err_o  <= 1'b0;
         init_o     <= 1'b0;
      end else begin
         init_o <= start_w;
         if (start_w) begin
            ready_o <= 1'b0;
            mask_o  <= '0;
            if (wdata_i[B_SNGL] || !wdata_i[B_NEED4]) begin
               step_q    <= STEP_HALT;
               cfg_err_o <= 1'b1;
            end else begin
               step_q    <= STEP_BASE;
               cfg_err_o <= 1'b0;
            end
         end else if (dwr_w) begin
            if (ready_o) begin
               mask_o <= wdata_i;
            end else begin
               case (step_q)
                  STEP_BASE: begin
                     vec_base_o <= {wdata_i[DW-1:LVL_W], {LVL_W{1'b0}}};
                     step_q     <= STEP_CASC;
                  end
                  STEP_CASC: step_q <= STEP_MODE;
                  STEP_MODE: begin
                     if (wdata_i[B_X86]) begin
                        auto_eoi_o <= wdata_i[B_AUTO];
                        ready_o    <= 1'b1;
                        cfg_err_o  <= 1'b0;
                        step_q     <= STEP_IDLE;
                     end else begin
                        cfg_err_o <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_w |=> (!ready_o && mask_o == '0 && init_o)); // R1

   AST_BAD_START_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_w && (wdata_i[B_SNGL] || !wdata_i[B_NEED4])) |=> (cfg_err_o && !ready_o)); // R2

   AST_BASE_ONLY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dwr_w && step_q == STEP_BASE) |=> $stable(vec_base_o)); // R3

   AST_READY_FROM_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_o) |-> $past(dwr_w && step_q == STEP_MODE && wdata_i[B_X86])); // R4

   AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!dwr_w && !start_w) |=> $stable(mask_o)); // R5

endmodule

// File: rtl/pic_cmd_seq_ops.sv
module pic_cmd_seq_ops
   import pic_cmd_seq_pkg::*;
#(
   parameter int DW    = 8,
   parameter int LVL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             op_wr_i,
   input  logic             start_i,
   input  logic [DW-1:0]    wdata_i,
   output logic             rotate_o,
   output logic             poll_o,
   output logic             issel_o,
   output logic             eoi_o,
   output logic             eoi_spec_o,
   output logic             prio_set_o,
   output logic [LVL_W-1:0] cmd_lvl_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rotate_o   <= 1'b0;
         poll_o     <= 1'b0;
         issel_o    <= 1'b0;
         eoi_o      <= 1'b0;
         eoi_spec_o <= 1'b0;
         prio_set_o <= 1'b0;
         cmd_lvl_o  <= '0;
      end else begin
         eoi_o      <= 1'b0;
         prio_set_o <= 1'b0;
         if (start_i) begin
            issel_o <= 1'b0;
         end else if (op_wr_i) begin
            if (wdata_i[B_SELW]) begin
               poll_o <= wdata_i[B_POLL];
               if (wdata_i[B_RDREG]) begin
                  issel_o <= wdata_i[B_ISSEL];
               end
            end else begin
               rotate_o  <= wdata_i[B_ROT];
               cmd_lvl_o <= wdata_i[LVL_W-1:0];
               if (wdata_i[B_EOI]) begin
                  eoi_o      <= 1'b1;
                  eoi_spec_o <= wdata_i[B_LVLSP];
               end else if (wdata_i[B_LVLSP] && wdata_i[B_ROT]) begin
                  prio_set_o <= 1'b1;
               end
            end
         end
      end
   end

   AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!op_wr_i && !start_i) |=> ($stable(issel_o) && $stable(poll_o))); // R6

   AST_EOI_FROM_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_o || prio_set_o) |-> $past(op_wr_i)); // R7

   AST_CMD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_o && !op_wr_i) |=> !eoi_o); // R7

endmodule

// File: rtl/pic_cmd_seq_rdport.sv
module pic_cmd_seq_rdport #(
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          rd_i,
   input  logic          addr_i,
   input  logic          poll_i,
   input  logic          issel_i,
   input  logic [DW-1:0] mask_i,
   input  logic [DW-1:0] irr_i,
   input  logic [DW-1:0] isr_i,
   output logic [DW-1:0] rdata_o,
   output logic          rd_unsup_o
);

   logic [DW-1:0] vec_w;

   // Per-bit choice between the in-service and request vectors
   for (genvar b = 0; b < DW; b++) begin : g_sel
      assign vec_w[b] = issel_i ? isr_i[b] : irr_i[b];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o    <= '0;
         rd_unsup_o <= 1'b0;
      end else begin
         rd_unsup_o <= rd_i & poll_i;
         if (rd_i) begin
            if (poll_i)      rdata_o <= '0;
            else if (addr_i) rdata_o <= mask_i;
            else             rdata_o <= vec_w;
         end
      end
   end

   AST_RD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i && !poll_i) |=> rdata_o == $past(mask_i)); // R8

   AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_i |=> $stable(rdata_o)); // R8

   AST_POLL_UNSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && poll_i) |=> (rd_unsup_o && rdata_o == '0)); // R9

endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq #(
   parameter int DW    = 8,
   parameter int LVL_W = $clog2(DW)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic             rd_i,
   input  logic             addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [DW-1:0]    irr_i,
   input  logic [DW-1:0]    isr_i,
   output logic [DW-1:0]    rdata_o,
   output logic             ready_o,
   output logic [DW-1:0]    mask_o,
   output logic [DW-1:0]    vec_base_o,
   output logic             auto_eoi_o,
   output logic             rotate_o,
   output logic             poll_o,
   output logic             init_o,
   output logic             eoi_o,
   output logic             eoi_spec_o,
   output logic             prio_set_o,
   output logic [LVL_W-1:0] cmd_lvl_o,
   output logic             cfg_err_o,
   output logic             rd_unsup_o
);

   if (DW != 8) begin : g_bad_width
      $error("pic_cmd_seq: command decode needs an 8-bit data bus");
   end
   if (LVL_W != $clog2(DW)) begin : g_bad_lvl
      $error("pic_cmd_seq: LVL_W must equal clog2(DW)");
   end

   logic start_w;
   logic op_wr_w;
   logic issel_w;

   pic_cmd_seq_init #(.DW(DW), .LVL_W(LVL_W)) u_init (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .ready_o    (ready_o),
      .mask_o     (mask_o),
      .vec_base_o (vec_base_o),
      .auto_eoi_o (auto_eoi_o),
      .cfg_err_o  (cfg_err_o),
      .init_o     (init_o),
      .start_o    (start_w),
      .op_wr_o    (op_wr_w)
   );

   pic_cmd_seq_ops #(.DW(DW), .LVL_W(LVL_W)) u_ops (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_wr_i    (op_wr_w),
      .start_i    (start_w),
      .wdata_i    (wdata_i),
      .rotate_o   (rotate_o),
      .poll_o     (poll_o),
      .issel_o    (issel_w),
      .eoi_o      (eoi_o),
      .eoi_spec_o (eoi_spec_o),
      .prio_set_o (prio_set_o),
      .cmd_lvl_o  (cmd_lvl_o)
   );

   pic_cmd_seq_rdport #(.DW(DW)) u_rd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_i       (rd_i),
      .addr_i     (addr_i),
      .poll_i     (poll_o),
      .issel_i    (issel_w),
      .mask_i     (mask_o),
      .irr_i      (irr_i),
      .isr_i      (isr_i),
      .rdata_o    (rdata_o),
      .rd_unsup_o (rd_unsup_o)
   );

   AST_OPS_NEED_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !addr_i && !wdata_i[4] && !ready_o) |=> ($stable(poll_o) && $stable(rotate_o))); // R5

endmodule

// File: tb/pic_cmd_seq_bench.sv
module pic_cmd_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0, irr = '0, isr = '0;
   logic [7:0] rdata, mask, vbase;
   logic [2:0] lvl;
   logic       ready, aeoi, rot, poll, init, eoi, espec, pset, err, unsup;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pic_cmd_seq u_pic_cmd_seq (
      .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
      .wdata_i(wdata), .irr_i(irr), .isr_i(isr), .rdata_o(rdata),
      .ready_o(ready), .mask_o(mask), .vec_base_o(vbase), .auto_eoi_o(aeoi),
      .rotate_o(rot), .poll_o(poll), .init_o(init), .eoi_o(eoi),
      .eoi_spec_o(espec), .prio_set_o(pset), .cmd_lvl_o(lvl),
      .cfg_err_o(err), .rd_unsup_o(unsup)
   );

   // {addr, data, ready, mask, base, err}
   localparam logic [26:0] TBL [14] = '{
      {1'b0, 8'h11, 1'b0, 8'h00, 8'h00, 1'b0},
      {1'b1, 8'h27, 1'b0, 8'h00, 8'h20, 1'b0},
      {1'b1, 8'h04, 1'b0, 8'h00, 8'h20, 1'b0},
      {1'b1, 8'h01, 1'b1, 8'h00, 8'h20, 1'b0},
      {1'b1, 8'hA5, 1'b1, 8'hA5, 8'h20, 1'b0},
      {1'b1, 8'h3C, 1'b1, 8'h3C, 8'h20, 1'b0},
      {1'b0, 8'h13, 1'b0, 8'h00, 8'h20, 1'b1},
      {1'b1, 8'h55, 1'b0, 8'h00, 8'h20, 1'b1},
      {1'b0, 8'h11, 1'b0, 8'h00, 8'h20, 1'b0},
      {1'b1, 8'hF7, 1'b0, 8'h00, 8'hF0, 1'b0},
      {1'b1, 8'h00, 1'b0, 8'h00, 8'hF0, 1'b0},
      {1'b1, 8'h00, 1'b0, 8'h00, 8'hF0, 1'b1},
      {1'b1, 8'h99, 1'b1, 8'h00, 8'hF0, 1'b0},
      {1'b1, 8'hFF, 1'b1, 8'hFF, 8'hF0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic do_rd(input logic a);
      @(negedge clk);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 flags", {ready, aeoi, rot, poll, init, eoi, pset, err, unsup}, 0);
      chk("R10 regs", {mask, vbase, rdata}, 0);
      // R5: not ready, data and command writes ignored
      do_wr(1'b1, 8'h77);
      chk("R5 data before init", {mask, vbase}, 0);
      do_wr(1'b0, 8'h0C);
      chk("R5 cmd before init", {poll, ready}, 0);

      // Table walk: R1 R2 R3 R4 R5
      for (int i = 0; i < 14; i++) begin
         do_wr(TBL[i][26], TBL[i][25:18]);
         chk($sformatf("R2/R3/R4/R5 table step %0d", i),
             {ready, mask, vbase, err}, {TBL[i][17:0]});
      end
      chk("R4 auto-eoi off", aeoi, 0);

      // R8 read paths
      irr = 8'h5A; isr = 8'h81;
      do_rd(1'b1);
      chk("R8 mask read", rdata, 8'hFF);
      do_rd(1'b0);
      chk("R8 request read", rdata, 8'h5A);
      @(negedge clk);
      chk("R8 read data held", rdata, 8'h5A);

      // R6 read-select
      do_wr(1'b0, 8'h0B);
      do_rd(1'b0);
      chk("R6 in-service selected", rdata, 8'h81);
      do_wr(1'b0, 8'h08);
      do_rd(1'b0);
      chk("R6 select kept when bit1=0", rdata, 8'h81);
      do_wr(1'b0, 8'h0A);
      do_rd(1'b0);
      chk("R6 request selected", rdata, 8'h5A);

      // R7 EOI / rotation words
      do_wr(1'b0, 8'h20);
      chk("R7 non-specific eoi", {eoi, espec, pset, rot, lvl}, {4'b1000, 3'd0});
      @(negedge clk);
      chk("R7 eoi one cycle", eoi, 0);
      do_wr(1'b0, 8'h63);
      chk("R7 specific eoi", {eoi, espec, pset, rot, lvl}, {4'b1100, 3'd3});
      do_wr(1'b0, 8'hC5);
      chk("R7 set priority", {eoi, pset, rot, lvl}, {3'b011, 3'd5});
      @(negedge clk);
      chk("R7 set priority one cycle", pset, 0);
      do_wr(1'b0, 8'h45);
      chk("R7 no priority without rotate", {eoi, pset, rot, lvl}, {3'b000, 3'd5});

      // R9 poll
      do_wr(1'b0, 8'h0C);
      chk("R9 poll set", poll, 1);
      do_rd(1'b0);
      chk("R9 read while polling", {unsup, rdata}, {1'b1, 8'h00});
      do_wr(1'b0, 8'h08);
      do_rd(1'b0);
      chk("R9 poll cleared read", {poll, unsup, rdata}, {2'b00, 8'h5A});

      // R1 restart clears read-select and mask, pulses init
      do_wr(1'b0, 8'h0B);
      do_wr(1'b0, 8'h11);
      chk("R1 restart", {init, ready, mask}, {2'b10, 8'h00});
      @(negedge clk);
      chk("R1 init one cycle", init, 0);
      do_rd(1'b0);
      chk("R1 select back to request", rdata, 8'h5A);
      do_wr(1'b1, 8'h4B);
      do_wr(1'b1, 8'hFF);
      chk("R3 cascade word no effect", {vbase, mask, ready}, {8'h48, 8'h00, 1'b0});
      do_wr(1'b1, 8'h03);
      chk("R4 auto-eoi mode", {ready, aeoi, err}, 3'b110);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule